// File: doc/BRIEF.md
# ATA Device Task File Register Block

This block is the device-side register file of a parallel ATA target. It watches the host's chip selects, three-bit address and the active-low read and write strobes. It resolves each access to one of the command-block or control-block registers, and it keeps the registers that the host loads: feature, sector count, the three LBA/cylinder bytes, drive/head and device control. It returns 8-bit register values on the low byte of the host data bus and moves 16-bit words between the data port and an internal sector buffer. The command engine behind it receives the command byte with a one-cycle start pulse, the LBA and count fields, the feature byte and the control bits. In return the engine supplies the status byte, the error byte and an interrupt-request pulse.

The host strobes are treated as synchronous to `clk`. A small access machine has three states. `ACC_IDLE` moves to `ACC_READ` when only the read strobe is low, and to `ACC_WRITE` when only the write strobe is low; with both strobes low it stays idle. `ACC_READ` returns to `ACC_IDLE` when the read strobe rises, which is the read-commit transition. `ACC_WRITE` returns to `ACC_IDLE` when the write strobe rises, which is the write-commit transition. The register selection is captured on entry to `ACC_READ` or `ACC_WRITE`. Write data is captured on every clock edge for which the next state is `ACC_WRITE`. All side effects take place at the commit edge.

Top module: `ata_taskfile`

## Requirements
- R1: With command-block select (`hst_cs1_n`=1, `hst_cs0_n`=0), addresses 2, 3, 4, 5 and 6 hold sector count, LBA bits 7:0, LBA 15:8, LBA 23:16 and drive/head. A write loads the byte and a read returns it on `hst_dout[7:0]` with `hst_dout[15:8]`=0. `tf_lba` is {drive/head[3:0], byte 5, byte 4, byte 3}, and `tf_lba_mode` is drive/head bit 6.
- R2: Address 1 reads `core_error` and writes the feature byte (`tf_feature`). Command-block address 7 reads the status byte. With control-block select (`hst_cs1_n`=0, `hst_cs0_n`=1), address 6 reads the same status (alternate) and writes device control. Control-block address 7 reads a drive-address byte {0, 1, ~head[3:0], ~drv, drv}, where drv is drive/head bit 4.
- R3: Command-block address 0 is the 16-bit data port. A write raises `wbuf_valid` for one cycle with the word on `wbuf_data`. A read returns `rbuf_data` on all 16 bits and raises `rbuf_take` for one cycle after the strobe ends.
- R4: A write to command-block address 7 raises `cmd_go` for exactly one cycle, updates `cmd_code` and clears a pending interrupt.
- R5: `core_irq_set` makes an interrupt pending. `hst_irq` equals pending AND NOT the interrupt-mask bit (device control bit 1) AND device selected. The mask bit appears on `irq_mask`.
- R6: A completed status read (command-block address 7) clears the pending interrupt, and an alternate-status read does not. When a set and a clear fall on the same cycle, the set wins.
- R7: The device is selected when drive/head bit 4 equals `dev_id`. When it is not selected, command writes are ignored, `hst_doe` stays 0 with `hst_dout`=0, status reads do not clear the interrupt, and `hst_irq` is 0. Drive/head writes are accepted either way.
- R8: Writing device control with bit 2 set holds soft reset. `eng_reset`=1, both status reads return 80h, the pending interrupt is cleared and command writes are ignored. Writing bit 2 clear then sets sector count and LBA 7:0 to 01h and LBA 15:8, LBA 23:16, drive/head and feature to 00h.
- R9: While the status busy bit (bit 7) is set, writes to command-block addresses 0 to 6 are ignored, but command writes still start a command.
- R10: Any other select/address combination (both selects high, both low, control-block addresses 0 to 5) reads as floating and writes have no effect.
- R11: After `rst_n` is asserted, sector count and LBA 7:0 are 01h and all other host-written registers are 00h. No interrupt is pending.
- R12: A write takes effect only at the clock edge after the write strobe rises. It uses the data present in the last cycle the strobe was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 1 | This device's number (0 or 1) |
| hst_cs1_n | input | 1 | Control-block select, active low |
| hst_cs0_n | input | 1 | Command-block select, active low |
| hst_addr | input | 3 | Register address |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_din | input | 16 | Host write data |
| hst_dout | output | 16 | Read data, zero when not driving |
| hst_doe | output | 1 | Read data drive enable |
| hst_irq | output | 1 | Interrupt request to host, active high |
| wbuf_valid | output | 1 | Data-port word written |
| wbuf_data | output | 16 | Data-port write word |
| rbuf_data | input | 16 | Next word for a data-port read |
| rbuf_take | output | 1 | Data-port word consumed |
| cmd_go | output | 1 | Command start pulse |
| cmd_code | output | 8 | Last accepted command byte |
| tf_feature | output | 8 | Feature byte |
| tf_seccnt | output | 8 | Sector count byte |
| tf_lba | output | 28 | LBA field |
| tf_lba_mode | output | 1 | LBA addressing selected |
| irq_mask | output | 1 | Interrupt mask bit |
| eng_reset | output | 1 | Soft reset held |
| core_status | input | 8 | Status byte from engine |
| core_error | input | 8 | Error byte from engine |
| core_irq_set | input | 1 | Raise interrupt pulse |

## Verification
A wrong access state or a wrong latched selection shows up at the edge after the strobe rises. It appears as a missing or misplaced `cmd_go`, `wbuf_valid` or `rbuf_take` pulse, or as a register that reads back wrongly on the next read cycle. A stale interrupt-pending flag appears on `hst_irq` in the very cycle after the status read commits. A wrong selection or busy decision instead corrupts a field that is visible on `tf_*` ports or on read-back. A soft-reset flag stuck in either state is visible at once on `eng_reset` and on every status read, and the missing reinitialisation shows in the first sector-count read after release.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
    localparam int SRST_BIT = 2;
    localparam int NIEN_BIT = 1;
    localparam int DRV_BIT  = 4;
    localparam int LBA_BIT  = 6;
    localparam int BSY_BIT  = 7;
    localparam int HEAD_W   = 4;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_DATA,
        RS_ERRFEAT,
        RS_SCNT,
        RS_SNUM,
        RS_CYLLO,
        RS_CYLHI,
        RS_DRVHD,
        RS_STATCMD,
        RS_ALTCTL,
        RS_DRVADR
    } tf_sel_t;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE
    } acc_state_t;
endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              cs1_n,
    input  logic              cs0_n,
    input  logic [ADDR_W-1:0] addr,
    output tf_sel_t           sel
);
    always_comb begin
        sel = RS_NONE;
        unique case ({cs1_n, cs0_n})
            2'b10: begin
                case (int'(addr))
                    0:       sel = RS_DATA;
                    1:       sel = RS_ERRFEAT;
                    2:       sel = RS_SCNT;
                    3:       sel = RS_SNUM;
                    4:       sel = RS_CYLLO;
                    5:       sel = RS_CYLHI;
                    6:       sel = RS_DRVHD;
                    7:       sel = RS_STATCMD;
                    default: sel = RS_NONE;
                endcase
            end
            2'b01: begin
                case (int'(addr))
                    6:       sel = RS_ALTCTL;
                    7:       sel = RS_DRVADR;
                    default: sel = RS_NONE;
                endcase
            end
            default: sel = RS_NONE;
        endcase
    end
endmodule

// File: rtl/ata_tf_access.sv
module ata_tf_access
    import ata_tf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  tf_sel_t           sel_live,
    input  logic [DATA_W-1:0] din,
    output logic              rd_commit,
    output logic              wr_commit,
    output tf_sel_t           sel_q,
    output logic [DATA_W-1:0] data_q
);
    acc_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ACC_IDLE: begin
                if (!wr_n && rd_n)      state_nx = ACC_WRITE;
                else if (!rd_n && wr_n) state_nx = ACC_READ;
            end
            ACC_READ:  if (rd_n) state_nx = ACC_IDLE;
            ACC_WRITE: if (wr_n) state_nx = ACC_IDLE;
            default:   state_nx = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACC_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= RS_NONE;
            data_q <= '0;
        end else begin
            if (state == ACC_IDLE && state_nx != ACC_IDLE) sel_q <= sel_live;
            if (state_nx == ACC_WRITE) data_q <= din;
        end
    end

    always_comb begin
        rd_commit = (state == ACC_READ)  && rd_n;
        wr_commit = (state == ACC_WRITE) && wr_n;
    end

    // R12
    wr_commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R12
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACC_WRITE && !wr_n) |=> $stable(sel_q));
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_id,
    input  logic              rd_commit,
    input  logic              wr_commit,
    input  tf_sel_t           sel_q,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_W-1:0]  core_status,
    input  logic              core_irq_set,
    output logic [REG_W-1:0]  feature,
    output logic [REG_W-1:0]  seccnt,
    output logic [REG_W-1:0]  secnum,
    output logic [REG_W-1:0]  cyllo,
    output logic [REG_W-1:0]  cylhi,
    output logic [REG_W-1:0]  drvhead,
    output logic [REG_W-1:0]  status_eff,
    output logic              dev_selected,
    output logic              irq_pend,
    output logic              srst,
    output logic              nien,
    output logic              cmd_go,
    output logic [REG_W-1:0]  cmd_code,
    output logic              wbuf_valid,
    output logic [DATA_W-1:0] wbuf_data,
    output logic              rbuf_take
);
    localparam logic [REG_W-1:0] ONE_INIT = REG_W'(1);
    localparam logic [REG_W-1:0] BSY_ONLY = REG_W'(1) << BSY_BIT;

    logic bsy, blk_wr, cmd_take, ctl_wr, srst_set, srst_rel, stat_clr;

    always_comb begin
        dev_selected = (drvhead[DRV_BIT] == dev_id);
        status_eff   = srst ? BSY_ONLY : core_status;
        bsy          = status_eff[BSY_BIT];
        blk_wr       = wr_commit && !bsy;
        cmd_take     = wr_commit && (sel_q == RS_STATCMD) && dev_selected && !srst;
        ctl_wr       = wr_commit && (sel_q == RS_ALTCTL);
        srst_set     = ctl_wr && wdata[SRST_BIT];
        srst_rel     = ctl_wr && srst && !wdata[SRST_BIT];
        stat_clr     = rd_commit && (sel_q == RS_STATCMD) && dev_selected;
    end

    // host-loaded bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            feature <= '0;
            seccnt  <= ONE_INIT;
            secnum  <= ONE_INIT;
            cyllo   <= '0;
            cylhi   <= '0;
            drvhead <= '0;
        end else if (srst_rel) begin
            feature <= '0;
            seccnt  <= ONE_INIT;
            secnum  <= ONE_INIT;
            cyllo   <= '0;
            cylhi   <= '0;
            drvhead <= '0;
        end else if (blk_wr) begin
            case (sel_q)
                RS_ERRFEAT: feature <= wdata[REG_W-1:0];
                RS_SCNT:    seccnt  <= wdata[REG_W-1:0];
                RS_SNUM:    secnum  <= wdata[REG_W-1:0];
                RS_CYLLO:   cyllo   <= wdata[REG_W-1:0];
                RS_CYLHI:   cylhi   <= wdata[REG_W-1:0];
                RS_DRVHD:   drvhead <= wdata[REG_W-1:0];
                default:    ;
            endcase
        end
    end

    // control, command and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst     <= 1'b0;
            nien     <= 1'b0;
            irq_pend <= 1'b0;
            cmd_go   <= 1'b0;
            cmd_code <= '0;
        end else begin
            if (ctl_wr) begin
                srst <= wdata[SRST_BIT];
                nien <= wdata[NIEN_BIT];
            end
            cmd_go <= cmd_take;
            if (cmd_take) cmd_code <= wdata[REG_W-1:0];
            if (srst || srst_set)         irq_pend <= 1'b0;
            else if (core_irq_set)        irq_pend <= 1'b1;
            else if (cmd_take || stat_clr) irq_pend <= 1'b0;
        end
    end

    // data port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbuf_valid <= 1'b0;
            wbuf_data  <= '0;
            rbuf_take  <= 1'b0;
        end else begin
            wbuf_valid <= blk_wr && (sel_q == RS_DATA);
            if (blk_wr && (sel_q == RS_DATA)) wbuf_data <= wdata;
            rbuf_take  <= rd_commit && (sel_q == RS_DATA) && dev_selected;
        end
    end

    // R6
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !core_irq_set) |=> !irq_pend);

    // R8
    srst_reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst) |-> (seccnt == ONE_INIT && secnum == ONE_INIT && cyllo == '0
                         && cylhi == '0 && drvhead == '0 && feature == '0));

    // R9
    bsy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && bsy && sel_q == RS_ERRFEAT) |=> $stable(feature));

    // R4
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go);

    // R7
    unsel_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && sel_q == RS_STATCMD && !dev_selected) |=> !cmd_go);

    // R3
    wbuf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wbuf_valid |=> !wbuf_valid);
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int REG_W  = 8,
    parameter int DATA_W = 16,
    localparam int LBA_W = 3 * REG_W + HEAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_id,
    input  logic              hst_cs1_n,
    input  logic              hst_cs0_n,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_rd_n,
    input  logic              hst_wr_n,
    input  logic [DATA_W-1:0] hst_din,
    output logic [DATA_W-1:0] hst_dout,
    output logic              hst_doe,
    output logic              hst_irq,
    output logic              wbuf_valid,
    output logic [DATA_W-1:0] wbuf_data,
    input  logic [DATA_W-1:0] rbuf_data,
    output logic              rbuf_take,
    output logic              cmd_go,
    output logic [REG_W-1:0]  cmd_code,
    output logic [REG_W-1:0]  tf_feature,
    output logic [REG_W-1:0]  tf_seccnt,
    output logic [LBA_W-1:0]  tf_lba,
    output logic              tf_lba_mode,
    output logic              irq_mask,
    output logic              eng_reset,
    input  logic [REG_W-1:0]  core_status,
    input  logic [REG_W-1:0]  core_error,
    input  logic              core_irq_set
);
    tf_sel_t           sel_live, sel_q;
    logic              rd_commit, wr_commit;
    logic [DATA_W-1:0] data_q;
    logic [REG_W-1:0]  secnum, cyllo, cylhi, drvhead, status_eff, drv_addr;
    logic              dev_selected, irq_pend, srst, nien;
    logic [DATA_W-1:0] rd_val;

    ata_tf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cs1_n (hst_cs1_n),
        .cs0_n (hst_cs0_n),
        .addr  (hst_addr),
        .sel   (sel_live)
    );

    ata_tf_access #(.DATA_W(DATA_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_n      (hst_rd_n),
        .wr_n      (hst_wr_n),
        .sel_live  (sel_live),
        .din       (hst_din),
        .rd_commit (rd_commit),
        .wr_commit (wr_commit),
        .sel_q     (sel_q),
        .data_q    (data_q)
    );

    ata_tf_regs #(.REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_id       (dev_id),
        .rd_commit    (rd_commit),
        .wr_commit    (wr_commit),
        .sel_q        (sel_q),
        .wdata        (data_q),
        .core_status  (core_status),
        .core_irq_set (core_irq_set),
        .feature      (tf_feature),
        .seccnt       (tf_seccnt),
        .secnum       (secnum),
        .cyllo        (cyllo),
        .cylhi        (cylhi),
        .drvhead      (drvhead),
        .status_eff   (status_eff),
        .dev_selected (dev_selected),
        .irq_pend     (irq_pend),
        .srst         (srst),
        .nien         (nien),
        .cmd_go       (cmd_go),
        .cmd_code     (cmd_code),
        .wbuf_valid   (wbuf_valid),
        .wbuf_data    (wbuf_data),
        .rbuf_take    (rbuf_take)
    );

    always_comb begin
        drv_addr = REG_W'({1'b0, 1'b1, ~drvhead[HEAD_W-1:0],
                           ~drvhead[DRV_BIT], drvhead[DRV_BIT]});
        case (sel_live)
            RS_DATA:              rd_val = rbuf_data;
            RS_ERRFEAT:           rd_val = DATA_W'(core_error);
            RS_SCNT:              rd_val = DATA_W'(tf_seccnt);
            RS_SNUM:              rd_val = DATA_W'(secnum);
            RS_CYLLO:             rd_val = DATA_W'(cyllo);
            RS_CYLHI:             rd_val = DATA_W'(cylhi);
            RS_DRVHD:             rd_val = DATA_W'(drvhead);
            RS_STATCMD, RS_ALTCTL: rd_val = DATA_W'(status_eff);
            RS_DRVADR:            rd_val = DATA_W'(drv_addr);
            default:              rd_val = '0;
        endcase
        hst_doe     = !hst_rd_n && hst_wr_n && (sel_live != RS_NONE) && dev_selected;
        hst_dout    = hst_doe ? rd_val : '0;
        hst_irq     = irq_pend && !nien && dev_selected;
        tf_lba      = {drvhead[HEAD_W-1:0], cylhi, cyllo, secnum};
        tf_lba_mode = drvhead[LBA_BIT];
        irq_mask    = nien;
        eng_reset   = srst;
    end

    // R10
    none_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_cs1_n == hst_cs0_n) |-> (hst_dout == '0));
endmodule

// File: tb/ata_taskfile_test.sv
`timescale 1ns/1ps
module ata_taskfile_test;
    localparam int SIG_RD = 0, SIG_IRQ = 1, SIG_GO = 2, SIG_LBA = 3, SIG_SCNT = 4,
                   SIG_FEAT = 5, SIG_WBUF = 6, SIG_TAKE = 7, SIG_CTL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs1 = 1'b1, cs0 = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [15:0] din = '0, rbuf_data = 16'hBEEF;
    logic [7:0] core_status = 8'h50, core_error = 8'h00;
    logic core_irq_set = 1'b0;
    logic [15:0] hst_dout, wbuf_data;
    logic hst_doe, hst_irq, wbuf_valid, rbuf_take, cmd_go, tf_lba_mode, irq_mask, eng_reset;
    logic [7:0] cmd_code, tf_feature, tf_seccnt;
    logic [27:0] tf_lba;

    typedef struct { string req; int sig; logic [31:0] exp; } item_t;
    item_t q[$];
    event sample_ev;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ata_taskfile uut (
        .clk(clk), .rst_n(rst_n), .dev_id(1'b0),
        .hst_cs1_n(cs1), .hst_cs0_n(cs0), .hst_addr(addr), .hst_rd_n(rd_n), .hst_wr_n(wr_n),
        .hst_din(din), .hst_dout(hst_dout), .hst_doe(hst_doe), .hst_irq(hst_irq),
        .wbuf_valid(wbuf_valid), .wbuf_data(wbuf_data), .rbuf_data(rbuf_data), .rbuf_take(rbuf_take),
        .cmd_go(cmd_go), .cmd_code(cmd_code), .tf_feature(tf_feature), .tf_seccnt(tf_seccnt),
        .tf_lba(tf_lba), .tf_lba_mode(tf_lba_mode), .irq_mask(irq_mask), .eng_reset(eng_reset),
        .core_status(core_status), .core_error(core_error), .core_irq_set(core_irq_set)
    );

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sig)
                    SIG_RD:   act = {15'b0, hst_doe, hst_dout};
                    SIG_IRQ:  act = {31'b0, hst_irq};
                    SIG_GO:   act = {23'b0, cmd_go, cmd_code};
                    SIG_LBA:  act = {3'b0, tf_lba_mode, tf_lba};
                    SIG_SCNT: act = {24'b0, tf_seccnt};
                    SIG_FEAT: act = {24'b0, tf_feature};
                    SIG_WBUF: act = {15'b0, wbuf_valid, wbuf_data};
                    SIG_TAKE: act = {31'b0, rbuf_take};
                    default:  act = {30'b0, eng_reset, irq_mask};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s (probe %0d): actual %h expected %h", it.req, it.sig, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(input string req, input int sig, input logic [31:0] exp);
        item_t it;
        it.req = req; it.sig = sig; it.exp = exp;
        q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    function automatic logic [31:0] drv(input logic [15:0] v);
        return {15'b0, 1'b1, v};
    endfunction

    task automatic hwrite(input logic c1, input logic c0, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); cs1 = c1; cs0 = c0; addr = a; din = d; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic hread(input logic c1, input logic c0, input logic [2:0] a,
                         input string req, input logic [31:0] exp);
        @(negedge clk); cs1 = c1; cs0 = c0; addr = a; rd_n = 1'b0;
        @(negedge clk); expect_v(req, SIG_RD, exp);
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic irq_pulse();
        @(negedge clk); core_irq_set = 1'b1;
        @(negedge clk); core_irq_set = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset values
        hread(1, 0, 2, "R11 seccnt reset", drv(16'h0001));
        hread(1, 0, 3, "R11 lba7 reset", drv(16'h0001));
        hread(1, 0, 6, "R11 drvhead reset", drv(16'h0000));
        expect_v("R11 no irq", SIG_IRQ, 0);
        hread(1, 0, 7, "R2 status read", drv(16'h0050));
        // R1 load and read back
        hwrite(1, 0, 2, 16'h0010);
        hwrite(1, 0, 3, 16'h0034);
        hwrite(1, 0, 4, 16'h0056);
        hwrite(1, 0, 5, 16'h0078);
        hwrite(1, 0, 6, 16'h00E9);
        hread(1, 0, 2, "R1 seccnt", drv(16'h0010));
        hread(1, 0, 4, "R1 lba15", drv(16'h0056));
        hread(1, 0, 6, "R1 drvhead", drv(16'h00E9));
        expect_v("R1 lba field", SIG_LBA, 32'h1978_5634);
        // R2 aliasing
        hwrite(1, 0, 1, 16'h00A5);
        expect_v("R2 feature write", SIG_FEAT, 32'hA5);
        core_error = 8'h04;
        hread(1, 0, 1, "R2 error read", drv(16'h0004));
        hread(0, 1, 7, "R2 drive address", drv(16'h005A));
        // R3 data port
        hwrite(1, 0, 0, 16'h1234);
        expect_v("R3 wbuf word", SIG_WBUF, 32'h1_1234);
        hread(1, 0, 0, "R3 data read", drv(16'hBEEF));
        expect_v("R3 rbuf take", SIG_TAKE, 1);
        // R4 command
        hwrite(1, 0, 7, 16'h0020);
        expect_v("R4 cmd go", SIG_GO, 32'h120);
        @(negedge clk);
        expect_v("R4 go single", SIG_GO, 32'h020);
        // R5 / R6 interrupt
        irq_pulse();
        expect_v("R5 irq raised", SIG_IRQ, 1);
        hread(0, 1, 6, "R6 alt status", drv(16'h0050));
        expect_v("R6 alt keeps irq", SIG_IRQ, 1);
        hread(1, 0, 7, "R6 status", drv(16'h0050));
        expect_v("R6 status clears irq", SIG_IRQ, 0);
        irq_pulse();
        hwrite(0, 1, 6, 16'h0002);
        expect_v("R5 masked", SIG_IRQ, 0);
        expect_v("R5 mask bit", SIG_CTL, 1);
        hwrite(0, 1, 6, 16'h0000);
        expect_v("R5 unmasked", SIG_IRQ, 1);
        hwrite(1, 0, 7, 16'h00EC);
        expect_v("R4 cmd clears irq", SIG_IRQ, 0);
        // R9 busy
        core_status = 8'hD0;
        hwrite(1, 0, 1, 16'h0011);
        expect_v("R9 feature held", SIG_FEAT, 32'hA5);
        hwrite(1, 0, 2, 16'h0099);
        expect_v("R9 seccnt held", SIG_SCNT, 32'h10);
        hwrite(1, 0, 7, 16'h00C8);
        expect_v("R9 cmd accepted", SIG_GO, 32'h1C8);
        core_status = 8'h50;
        // R7 device selection
        hwrite(1, 0, 6, 16'h00F0);
        hread(1, 0, 2, "R7 float unselected", 0);
        hwrite(1, 0, 7, 16'h0030);
        expect_v("R7 cmd ignored", SIG_GO, 32'h0C8);
        irq_pulse();
        expect_v("R7 irq hidden", SIG_IRQ, 0);
        hread(1, 0, 7, "R7 status float", 0);
        hwrite(1, 0, 6, 16'h00E0);
        expect_v("R7 pending kept", SIG_IRQ, 1);
        hread(1, 0, 7, "R6 status", drv(16'h0050));
        // R10 invalid
        hread(1, 1, 2, "R10 no select", 0);
        hread(0, 0, 7, "R10 both select", 0);
        hwrite(0, 1, 3, 16'h0004);
        expect_v("R10 ctl untouched", SIG_CTL, 0);
        // R8 soft reset
        irq_pulse();
        hwrite(0, 1, 6, 16'h0004);
        expect_v("R8 engine reset", SIG_CTL, 2);
        expect_v("R8 irq cleared", SIG_IRQ, 0);
        hread(1, 0, 7, "R8 status busy", drv(16'h0080));
        hread(0, 1, 6, "R8 alt busy", drv(16'h0080));
        hwrite(1, 0, 7, 16'h0020);
        expect_v("R8 cmd ignored", SIG_GO, 32'h0C8);
        hwrite(0, 1, 6, 16'h0000);
        expect_v("R8 released", SIG_CTL, 0);
        hread(1, 0, 2, "R8 seccnt reinit", drv(16'h0001));
        expect_v("R8 feature reinit", SIG_FEAT, 0);
        expect_v("R8 lba reinit", SIG_LBA, 32'h0000_0001);
        // R6 set beats clear on the same edge
        @(negedge clk); cs1 = 1; cs0 = 0; addr = 7; rd_n = 1'b0;
        @(negedge clk); rd_n = 1'b1; core_irq_set = 1'b1;
        @(negedge clk); core_irq_set = 1'b0;
        expect_v("R6 set wins", SIG_IRQ, 1);
        // R12 commit timing and data capture
        @(negedge clk); cs1 = 1; cs0 = 0; addr = 1; din = 16'h0033; wr_n = 1'b0;
        @(negedge clk); expect_v("R12 no early effect", SIG_FEAT, 0);
        din = 16'h0044;
        @(negedge clk); wr_n = 1'b1; din = 16'h0055;
        @(negedge clk); expect_v("R12 last low data", SIG_FEAT, 32'h44);
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule